// File: doc/BRIEF.md
# Bus Arbitration and Target Selection Controller

This block is the initiator-side sequencer that claims a shared parallel peripheral bus and then selects one target on it. After a start pulse it watches the BSY and SEL lines until the bus has been idle for a fixed number of cycles. It then places its own one-hot ID on the data lines together with BSY. After an arbitration delay it judges the bus. If another device has raised SEL, or an ID bit above its own is present, it counts a loss and begins again with the bus-free wait. A retry budget limits the number of attempts.

After a win it raises SEL and ATN and, after a settle time, drives the OR of its own ID and the target ID. It then releases BSY while holding SEL and waits for the target to answer with BSY. When the target answers, the controller drops SEL, then ATN, then its data drive, and reports success. If the target does not answer within the timeout, it drops SEL, ATN and data together and reports failure. Information transfer after selection is handled elsewhere.

States and transitions: ST_IDLE goes to ST_FREE on `start`. ST_FREE goes to ST_ARB after FREE_CYC idle cycles in a row. ST_ARB goes to ST_LOST on a loss and to ST_CLAIM on a win. ST_LOST goes back to ST_FREE, or to ST_FAIL once the budget is spent. ST_CLAIM goes to ST_ADDR after SETTLE cycles, and ST_ADDR goes to ST_WAIT after SETTLE cycles. ST_WAIT goes to ST_REL_SEL when the target raises BSY, or to ST_FAIL on timeout. From there the sequence runs ST_REL_SEL → ST_REL_ATN → ST_FINISH → ST_IDLE, and ST_FAIL goes to ST_IDLE.

Top module: `bus_claim_select`

## Requirements
- R1: After reset every bus drive (`bsy_out`, `sel_out`, `atn_out`, `data_oe`) and every status output (`done`, `result_ok`, `arb_lost`) is 0.
- R2: After `start`, nothing is driven until `bsy_in` and `sel_in` have both been low for FREE_CYC consecutive clock edges. `bsy_out` rises at the FREE_CYC-th edge after the bus goes free.
- R3: During arbitration the block asserts `bsy_out` and `data_oe` and drives exactly its own one-hot ID on `data_out`, with SEL and ATN low.
- R4: If `data_in` carries any bit above the own-ID bit when arbitration is judged, the attempt is lost. `arb_lost` pulses for one cycle with all drives released, and the block retries from the bus-free wait.
- R5: If `sel_in` is high when arbitration is judged, the attempt is lost in the same way. A SEL from another device together with a higher ID bit in the same cycle counts as one loss.
- R6: ID bits below the own-ID bit on `data_in` never cause a loss.
- R7: After a win, SEL and ATN are asserted with BSY still held. `sel_out` is never high without `atn_out`.
- R8: In the handoff, `bsy_out` is low while `sel_out` stays high and `data_out` equals own ID OR target ID (for example 0x24 for one-hot IDs 0x04 and 0x20).
- R9: When the target raises BSY, SEL falls first, ATN falls on a later cycle, and `data_oe` falls on a still later cycle, in the same cycle as a one-cycle `done` with `result_ok` = 1.
- R10: If the target does not raise BSY, the handoff (SEL high, BSY low) lasts exactly SEL_TIMEOUT cycles. SEL, ATN and data drive then drop together, with `done` = 1 and `result_ok` = 0.
- R11: After RETRY_LIMIT (default 64) lost attempts the block reports `done` with `result_ok` = 0 without ever asserting SEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to claim the bus and select |
| own_id | input | ID_W | One-hot ID of this initiator |
| tgt_id | input | ID_W | One-hot ID of the target |
| bsy_in | input | 1 | Sampled BSY line (wire-OR of all drivers) |
| sel_in | input | 1 | Sampled SEL line from other devices |
| data_in | input | ID_W | Sampled data lines |
| bsy_out | output | 1 | BSY drive |
| sel_out | output | 1 | SEL drive |
| atn_out | output | 1 | ATN drive |
| data_oe | output | 1 | Data bus drive enable |
| data_out | output | ID_W | Data driven when `data_oe` is high |
| done | output | 1 | One-cycle end-of-sequence flag |
| result_ok | output | 1 | With `done`: 1 = target selected, 0 = failure |
| arb_lost | output | 1 | One-cycle pulse per lost arbitration attempt |

## Verification
The two loss causes in arbitration, a competing SEL and a higher-priority ID bit, can both be present in the arbitration judgment cycle. The bench provokes this with a modelled competitor that raises SEL and a higher data bit at once, but only for one attempt. It judges the result by counting `arb_lost` pulses, which must be exactly one, and by requiring that the retry still ends in a successful selection.

// File: rtl/claim_pkg.sv
package claim_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FREE,
        ST_ARB,
        ST_LOST,
        ST_CLAIM,
        ST_ADDR,
        ST_WAIT,
        ST_REL_SEL,
        ST_REL_ATN,
        ST_FINISH,
        ST_FAIL
    } claim_state_e;

endpackage

// File: rtl/bus_free_det.sv
module bus_free_det #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bsy,
    input  logic sel,
    output logic free_ok
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          idle_now;

    assign idle_now = !bsy && !sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en && idle_now) begin
            if (cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign free_ok = en && idle_now && (cnt_q == LAST);

endmodule

// File: rtl/id_prio_cmp.sv
module id_prio_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] bus,
    output logic         higher
);
    logic [W-1:0] below_incl;
    logic [W-1:0] above;

    // Bits at and below the own position; everything else outranks us.
    assign below_incl = (own << 1) - 1'b1;
    assign above      = ~below_incl;
    assign higher     = |(bus & above);

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bus_claim_select.sv
module bus_claim_select
    import claim_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int FREE_CYC    = 4,
    parameter int ARB_CYC     = 3,
    parameter int SETTLE      = 2,
    parameter int SEL_TIMEOUT = 50000,
    parameter int RETRY_LIMIT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] own_id,
    input  logic [ID_W-1:0] tgt_id,
    input  logic            bsy_in,
    input  logic            sel_in,
    input  logic [ID_W-1:0] data_in,
    output logic            bsy_out,
    output logic            sel_out,
    output logic            atn_out,
    output logic            data_oe,
    output logic [ID_W-1:0] data_out,
    output logic            done,
    output logic            result_ok,
    output logic            arb_lost
);
    localparam int MAX_A = (ARB_CYC > SETTLE) ? ARB_CYC : SETTLE;
    localparam int MAXC  = (SEL_TIMEOUT > MAX_A) ? SEL_TIMEOUT : MAX_A;
    localparam int TW    = $clog2(MAXC + 1);
    localparam int RW    = $clog2(RETRY_LIMIT + 1);

    localparam logic [TW-1:0] ARB_LAST    = TW'(ARB_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE - 1);
    localparam logic [TW-1:0] SETTLE_MIN  = TW'(SETTLE);
    localparam logic [TW-1:0] WAIT_LAST   = TW'(SEL_TIMEOUT - 1);
    localparam logic [RW-1:0] RETRY_INIT  = RW'(RETRY_LIMIT);
    localparam logic [RW-1:0] RETRY_ONE   = RW'(1);

    claim_state_e  state_q, state_d;
    logic [RW-1:0] retry_q;
    logic [TW-1:0] tmr;
    logic          free_ok;
    logic          higher_seen;
    logic          lost_now;

    bus_free_det #(.CYC(FREE_CYC)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state_q == ST_FREE),
        .bsy     (bsy_in),
        .sel     (sel_in),
        .free_ok (free_ok)
    );

    id_prio_cmp #(.W(ID_W)) u_prio (
        .own    (own_id),
        .bus    (data_in),
        .higher (higher_seen)
    );

    phase_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (tmr)
    );

    assign lost_now = sel_in || higher_seen;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FREE;
            end
            ST_FREE: begin
                if (free_ok) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (tmr == ARB_LAST) begin
                    state_d = lost_now ? ST_LOST : ST_CLAIM;
                end
            end
            ST_LOST: begin
                state_d = (retry_q <= RETRY_ONE) ? ST_FAIL : ST_FREE;
            end
            ST_CLAIM: begin
                if (tmr == SETTLE_LAST) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (tmr == SETTLE_LAST) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr >= SETTLE_MIN && bsy_in) begin
                    state_d = ST_REL_SEL;
                end else if (tmr == WAIT_LAST) begin
                    state_d = ST_FAIL;
                end
            end
            ST_REL_SEL: state_d = ST_REL_ATN;
            ST_REL_ATN: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and retry budget.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                retry_q <= RETRY_INIT;
            end else if (state_q == ST_LOST && retry_q != '0) begin
                retry_q <= retry_q - 1'b1;
            end
        end
    end

    // Output decode.
    always_comb begin
        bsy_out   = 1'b0;
        sel_out   = 1'b0;
        atn_out   = 1'b0;
        data_oe   = 1'b0;
        data_out  = '0;
        done      = 1'b0;
        result_ok = 1'b0;
        arb_lost  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FREE: begin
            end
            ST_ARB: begin
                bsy_out  = 1'b1;
                data_oe  = 1'b1;
                data_out = own_id;
            end
            ST_LOST: begin
                arb_lost = 1'b1;
            end
            ST_CLAIM: begin
                bsy_out  = 1'b1;
                sel_out  = 1'b1;
                atn_out  = 1'b1;
                data_oe  = 1'b1;
                data_out = own_id;
            end
            ST_ADDR: begin
                bsy_out  = 1'b1;
                sel_out  = 1'b1;
                atn_out  = 1'b1;
                data_oe  = 1'b1;
                data_out = own_id | tgt_id;
            end
            ST_WAIT: begin
                sel_out  = 1'b1;
                atn_out  = 1'b1;
                data_oe  = 1'b1;
                data_out = own_id | tgt_id;
            end
            ST_REL_SEL: begin
                atn_out  = 1'b1;
                data_oe  = 1'b1;
                data_out = own_id | tgt_id;
            end
            ST_REL_ATN: begin
                data_oe  = 1'b1;
                data_out = own_id | tgt_id;
            end
            ST_FINISH: begin
                done      = 1'b1;
                result_ok = 1'b1;
            end
            ST_FAIL: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/claim_checks.sv
module claim_checks #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bsy_out,
    input logic            sel_out,
    input logic            atn_out,
    input logic            data_oe,
    input logic [ID_W-1:0] data_out,
    input logic            done,
    input logic            result_ok,
    input logic            arb_lost
);
    assert_arb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_out && !sel_out) |-> (data_oe && $onehot0(data_out)));

    assert_lost_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !(bsy_out || sel_out || atn_out || data_oe || done));

    assert_sel_with_atn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_out |-> atn_out);

    assert_sel_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_out |-> data_oe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ok_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_ok) |-> (!$past(atn_out) && $past(data_oe)));

    assert_sel_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_out) |-> (atn_out || done));

endmodule

bind bus_claim_select claim_checks #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bsy_out   (bsy_out),
    .sel_out   (sel_out),
    .atn_out   (atn_out),
    .data_oe   (data_oe),
    .data_out  (data_out),
    .done      (done),
    .result_ok (result_ok),
    .arb_lost  (arb_lost)
);

// File: tb/sim_bus_claim_select.sv
`timescale 1ns/1ps
module sim_bus_claim_select;

    localparam int ID_W     = 8;
    localparam int FREE_CYC = 4;
    localparam int TMO      = 300;
    localparam int TGT_LAT  = 5;

    typedef struct packed {
        logic [7:0] own;
        logic [7:0] tgt;
        logic [7:0] comp;
        logic [7:0] storm;
        logic       use_sel;
        logic       resp;
        logic       exp_ok;
        logic [7:0] exp_lost;
        logic [7:0] exp_hs;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'h04, 8'h20, 8'h00, 8'd0,  1'b0, 1'b1, 1'b1, 8'd0,  8'h24},
        '{8'h80, 8'h01, 8'h7F, 8'd3,  1'b0, 1'b1, 1'b1, 8'd0,  8'h81},
        '{8'h02, 8'h40, 8'h10, 8'd3,  1'b0, 1'b1, 1'b1, 8'd3,  8'h42},
        '{8'h08, 8'h01, 8'h00, 8'd2,  1'b1, 1'b1, 1'b1, 8'd2,  8'h09},
        '{8'h01, 8'h80, 8'h80, 8'd1,  1'b1, 1'b1, 1'b1, 8'd1,  8'h81},
        '{8'h10, 8'h02, 8'h20, 8'd70, 1'b0, 1'b1, 1'b0, 8'd64, 8'h00},
        '{8'h40, 8'h04, 8'h00, 8'd0,  1'b0, 1'b0, 1'b0, 8'd0,  8'h44}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ID_W-1:0] own_id = '0, tgt_id = '0;
    logic bsy_in, sel_in;
    logic [ID_W-1:0] data_in;
    logic bsy_out, sel_out, atn_out, data_oe, done, result_ok, arb_lost;
    logic [ID_W-1:0] data_out;

    // Bench-driven environment configuration (initial block only).
    logic [7:0] comp_bits = '0, storm_init = '0;
    logic       comp_sel = 1'b0, tgt_en = 1'b0, ext_bsy = 1'b0, rec_clr = 1'b0;

    // Environment state (posedge block only).
    logic [7:0]  storm_left, lost_cnt, hs_data;
    logic        tgt_bsy, hs_seen, p_sel, p_atn, p_oe;
    logic [31:0] tgt_wait, wait_cnt, cyc, sel_fall, atn_fall, oe_fall, done_cyc;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    logic comp_on;
    assign comp_on = (storm_left != 0) && bsy_out && !sel_out;
    assign bsy_in  = bsy_out | tgt_bsy | ext_bsy;
    assign sel_in  = comp_on && comp_sel;
    assign data_in = (data_oe ? data_out : '0) | (comp_on ? comp_bits : '0);

    bus_claim_select #(.SEL_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .own_id(own_id), .tgt_id(tgt_id),
        .bsy_in(bsy_in), .sel_in(sel_in), .data_in(data_in),
        .bsy_out(bsy_out), .sel_out(sel_out), .atn_out(atn_out), .data_oe(data_oe),
        .data_out(data_out), .done(done), .result_ok(result_ok), .arb_lost(arb_lost)
    );

    always @(posedge clk) begin
        cyc <= (rst_n === 1'b1) ? cyc + 1 : 32'd0;
        if (rec_clr) begin
            storm_left <= storm_init; lost_cnt <= 0; tgt_bsy <= 0; tgt_wait <= 0;
            hs_seen <= 0; hs_data <= 0; wait_cnt <= 0;
            sel_fall <= 0; atn_fall <= 0; oe_fall <= 0; done_cyc <= 0;
            p_sel <= 0; p_atn <= 0; p_oe <= 0;
        end else begin
            if (arb_lost) begin
                lost_cnt <= lost_cnt + 1;
                if (storm_left != 0) storm_left <= storm_left - 1;
            end
            if (tgt_en && sel_out && !bsy_out && ((data_in & tgt_id) != 0))
                tgt_wait <= tgt_wait + 1;
            if (tgt_wait == TGT_LAT) tgt_bsy <= 1'b1;
            if (sel_out && !bsy_out) begin
                hs_seen <= 1'b1; hs_data <= data_out; wait_cnt <= wait_cnt + 1;
            end
            if (p_sel && !sel_out) sel_fall <= cyc;
            if (p_atn && !atn_out) atn_fall <= cyc;
            if (p_oe && !data_oe) oe_fall <= cyc;
            if (done) done_cyc <= cyc;
            p_sel <= sel_out; p_atn <= atn_out; p_oe <= data_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic clear_env(input vec_t v);
        @(negedge clk);
        own_id = v.own; tgt_id = v.tgt; comp_bits = v.comp; storm_init = v.storm;
        comp_sel = v.use_sel; tgt_en = v.resp; rec_clr = 1'b1;
        @(negedge clk);
        rec_clr = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output bit ok);
        seen = 0; ok = 0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; ok = result_ok; end
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        bit seen, ok;
        vec_t v;
        rec_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rec_clr = 1'b0;
        @(negedge clk);
        chk(!(bsy_out | sel_out | atn_out | data_oe | done | result_ok | arb_lost),
            "R1 reset outputs", {bsy_out, sel_out, atn_out, data_oe, done, result_ok, arb_lost}, 0);

        // Table walk: R3..R11
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            clear_env(v);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(seen, ok);
            chk(seen && ok == v.exp_ok, v.exp_ok ? "R9 done ok" : "R10/R11 done fail", ok, v.exp_ok);
            chk(lost_cnt == v.exp_lost, "R4/R5/R6/R11 loss count", lost_cnt, v.exp_lost);
            if (v.exp_hs != 0) begin
                chk(hs_seen && hs_data == v.exp_hs, "R8 handoff id pair", hs_data, v.exp_hs);
            end else begin
                chk(!hs_seen, "R11 no selection after budget", hs_seen, 0);
            end
            if (v.exp_ok) begin
                chk(sel_fall < atn_fall && atn_fall < oe_fall && oe_fall == done_cyc,
                    "R9 release order", {sel_fall[7:0], atn_fall[7:0], oe_fall[7:0]}, done_cyc);
            end
            if (!v.resp) begin
                chk(wait_cnt == TMO, "R10 timeout window", wait_cnt, TMO);
                chk(sel_fall == atn_fall && atn_fall == oe_fall && oe_fall == done_cyc,
                    "R10 joint drop", sel_fall, done_cyc);
            end
        end

        // Directed: bus-free wait (R2), arbitration drive (R3), win sequence (R7)
        v = VEC[0];
        clear_env(v);
        ext_bsy = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(!bsy_out && !data_oe, "R2 hold off while busy", bsy_out, 0);
        ext_bsy = 1'b0;
        for (int i = 1; i <= FREE_CYC; i++) begin
            @(negedge clk);
            if (i < FREE_CYC) chk(!bsy_out, "R2 early drive", bsy_out, 0);
            else chk(bsy_out, "R2 drive at free count", bsy_out, 1);
        end
        chk(data_oe && data_out == v.own && !sel_out && !atn_out, "R3 arbitration drive",
            data_out, v.own);
        for (int i = 0; i < 20 && !sel_out; i++) @(negedge clk);
        chk(sel_out && atn_out && bsy_out && data_out == v.own, "R7 claim with BSY held",
            {sel_out, atn_out, bsy_out}, 3'b111);
        wait_done(seen, ok);
        chk(seen && ok, "R9 directed success", ok, 1);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

endmodule